// File: doc/BRIEF.md
# Virtually Indexed Instruction Cache

This block is a read-only, direct-mapped instruction cache of 4 KB built from 256 lines of four 32-bit words. A fetch picks its line from virtual address bits while the address translation runs beside it. The physical address then arrives in the response cycle and is compared with the stored 22-bit line tag. A fetch request is taken on one clock edge, and the hit flag, the selected instruction word and any parity error flags are valid during the next cycle.

The arrays are filled from memory a whole line at a time by a small refill state machine. Each word is stored with an even parity bit. Each tag is stored with an even parity bit computed over the tag and the set valid bit. Line valid bits are kept in flops, so reset clears them all at once. An invalidate port clears the valid bit of one line.

The refill machine has three states. FILL_IDLE waits for a refill start. The transition "start" (refill start while idle) captures the line index, the tag and the parity-inject mask, clears that line's valid bit, and enters FILL_WORDS. In FILL_WORDS, each cycle with the word strobe high writes the next word; the transition "last word" (fourth word written) enters FILL_COMMIT. FILL_COMMIT writes the tag and sets the valid bit, and the transition "commit" always returns to FILL_IDLE.

Top module: `icache_vipt`

## Requirements
- R1: After reset every line is invalid: any fetch gets rsp_valid=1 with rsp_hit=0 and both parity flags 0, and refill_busy is 0.
- R2: A fetch requested on one clock edge raises rsp_valid in the following cycle. On a hit, rsp_instr is the word of the line chosen by req_vaddr[3:2].
- R3: The line tag is compared with xlat_paddr[31:10]. A difference in any of those bits gives a miss, and a difference only in bits [9:0] does not.
- R4: The line is selected by req_vaddr[11:4] alone. Virtual bits [31:12] do not affect the result, and a line refilled at one index does not hit at another.
- R5: From the cycle after a refill start until the commit edge, the line being refilled misses, and refill_busy is 1. After the commit it hits with the new contents.
- R6: An invalidate pulse makes the line at inval_vaddr[11:4] miss and leaves other lines hitting.
- R7: A refill of an index that already holds a line replaces it, so the old physical tag then misses.
- R8: A tag whose stored parity is wrong sets rsp_tag_perr and forces a miss. Bit 4 of refill_perr_inject flips the stored tag parity of that refill.
- R9: A selected word whose stored parity is wrong, in a valid line with a matching tag, sets rsp_data_perr and forces a miss. The other words of the line still hit. Bit k (0..3) of refill_perr_inject flips the parity of word k.
- R10: A refill start that arrives while refill_busy is 1 is ignored and does not disturb the line it names.
- R11: A refill without injected errors stores parity that never flags: hits on such lines have both parity flags 0.
- R12: When rsp_valid is 0, rsp_hit, rsp_tag_perr and rsp_data_perr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch request strobe |
| req_vaddr | input | 32 | Virtual fetch address |
| xlat_paddr | input | 32 | Translated physical address, valid in the response cycle |
| rsp_valid | output | 1 | Response cycle marker |
| rsp_hit | output | 1 | Fetch hit |
| rsp_instr | output | 32 | Selected instruction word |
| rsp_tag_perr | output | 1 | Tag parity error seen |
| rsp_data_perr | output | 1 | Word parity error seen |
| inval_valid | input | 1 | Invalidate strobe |
| inval_vaddr | input | 32 | Virtual address of the line to invalidate |
| refill_start | input | 1 | Begin a line refill |
| refill_vaddr | input | 32 | Virtual address selecting the refilled line |
| refill_paddr | input | 32 | Physical address supplying the new tag |
| refill_wvalid | input | 1 | Refill word strobe |
| refill_word | input | 32 | Refill word, taken in order 0..3 |
| refill_perr_inject | input | 5 | Stored-parity flip mask, captured at start |
| refill_busy | output | 1 | Refill machine not idle |

## Verification
The wrong internal state that matters most is a stale or early valid bit. It shows up as a hit on a line that is being refilled or was invalidated, and it is visible in the response cycle of the very next fetch to that index. A wrong word counter or a wrong index latch in the refill machine shows up as the wrong rsp_instr on the first fetch after the commit. Corrupted stored parity shows up in the same response cycle as a raised error flag together with a forced miss.

// File: rtl/icache_pkg.sv
package icache_pkg;

    typedef enum logic [1:0] {
        FILL_IDLE,
        FILL_WORDS,
        FILL_COMMIT
    } fill_state_t;

endpackage

// File: rtl/icache_sram.sv
module icache_sram #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 23,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/icache_hit_check.sv
module icache_hit_check #(
    parameter int TAG_W  = 22,
    parameter int WORD_W = 32
) (
    input  logic              active,
    input  logic              line_valid,
    input  logic [TAG_W-1:0]  stored_tag,
    input  logic              stored_tpar,
    input  logic [WORD_W-1:0] stored_word,
    input  logic              stored_wpar,
    input  logic [TAG_W-1:0]  xlat_tag,
    output logic              hit,
    output logic              tag_perr,
    output logic              data_perr
);

    logic live;
    logic tag_bad;
    logic word_bad;
    logic match;

    always_comb begin
        live      = active & line_valid;
        // even parity over tag field, valid bit (set) and stored parity
        tag_bad   = ^{stored_tag, 1'b1, stored_tpar};
        word_bad  = ^{stored_word, stored_wpar};
        match     = (stored_tag == xlat_tag);
        tag_perr  = live & tag_bad;
        data_perr = live & match & ~tag_bad & word_bad;
        hit       = live & match & ~tag_bad & ~word_bad;
    end

endmodule

// File: rtl/icache_refill_ctrl.sv
module icache_refill_ctrl
    import icache_pkg::*;
#(
    parameter int IDX_W      = 8,
    parameter int TAG_W      = 22,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    localparam int OFF_W     = $clog2(LINE_WORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [IDX_W-1:0]       start_idx,
    input  logic [TAG_W-1:0]       start_tag,
    input  logic [LINE_WORDS:0]    start_inject,
    input  logic                   wvalid,
    input  logic [WORD_W-1:0]      word,
    output logic                   busy,
    output logic                   clr_en,
    output logic [IDX_W-1:0]       clr_idx,
    output logic                   set_en,
    output logic [IDX_W-1:0]       set_idx,
    output logic                   data_we,
    output logic [IDX_W+OFF_W-1:0] data_waddr,
    output logic [WORD_W:0]        data_wdata,
    output logic                   tag_we,
    output logic [IDX_W-1:0]       tag_waddr,
    output logic [TAG_W:0]         tag_wdata
);

    fill_state_t             state_q, state_d;
    logic [IDX_W-1:0]        idx_q;
    logic [TAG_W-1:0]        tag_q;
    logic [LINE_WORDS:0]     inj_q;
    logic [OFF_W-1:0]        cnt_q;
    logic                    last_word;

    assign last_word = (cnt_q == OFF_W'(LINE_WORDS - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_IDLE:   if (start)                  state_d = FILL_WORDS;
            FILL_WORDS:  if (wvalid && last_word)    state_d = FILL_COMMIT;
            FILL_COMMIT:                             state_d = FILL_IDLE;
            default:                                 state_d = FILL_IDLE;
        endcase
    end

    // state register and captured refill context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
            idx_q   <= '0;
            tag_q   <= '0;
            inj_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                FILL_IDLE: begin
                    if (start) begin
                        idx_q <= start_idx;
                        tag_q <= start_tag;
                        inj_q <= start_inject;
                        cnt_q <= '0;
                    end
                end
                FILL_WORDS: begin
                    if (wvalid) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                FILL_COMMIT: begin
                    cnt_q <= '0;
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        clr_en     = 1'b0;
        clr_idx    = start_idx;
        set_en     = 1'b0;
        set_idx    = idx_q;
        data_we    = 1'b0;
        data_waddr = {idx_q, cnt_q};
        data_wdata = {^word ^ inj_q[cnt_q], word};
        tag_we     = 1'b0;
        tag_waddr  = idx_q;
        tag_wdata  = {^{tag_q, 1'b1} ^ inj_q[LINE_WORDS], tag_q};
        unique case (state_q)
            FILL_IDLE: begin
                clr_en = start;
            end
            FILL_WORDS: begin
                busy    = 1'b1;
                data_we = wvalid;
            end
            FILL_COMMIT: begin
                busy   = 1'b1;
                tag_we = 1'b1;
                set_en = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/icache_vipt.sv
module icache_vipt #(
    parameter int VADDR_W    = 32,
    parameter int PADDR_W    = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NUM_LINES  = 256,
    parameter int PAGE_BITS  = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [VADDR_W-1:0]    req_vaddr,
    input  logic [PADDR_W-1:0]    xlat_paddr,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic [WORD_W-1:0]     rsp_instr,
    output logic                  rsp_tag_perr,
    output logic                  rsp_data_perr,
    input  logic                  inval_valid,
    input  logic [VADDR_W-1:0]    inval_vaddr,
    input  logic                  refill_start,
    input  logic [VADDR_W-1:0]    refill_vaddr,
    input  logic [PADDR_W-1:0]    refill_paddr,
    input  logic                  refill_wvalid,
    input  logic [WORD_W-1:0]     refill_word,
    input  logic [LINE_WORDS:0]   refill_perr_inject,
    output logic                  refill_busy
);

    localparam int BYTE_W     = $clog2(WORD_W / 8);
    localparam int OFF_W      = $clog2(LINE_WORDS);
    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int IDX_LO     = BYTE_W + OFF_W;
    localparam int IDX_HI     = IDX_LO + IDX_W;
    localparam int TAG_W      = PADDR_W - PAGE_BITS;
    localparam int DATA_DEPTH = NUM_LINES * LINE_WORDS;

    logic [IDX_W-1:0]       req_idx;
    logic [OFF_W-1:0]       req_off;
    logic [IDX_W-1:0]       inv_idx;
    logic [IDX_W-1:0]       fill_idx;
    logic [TAG_W-1:0]       xlat_tag;
    logic [TAG_W-1:0]       fill_tag;

    logic [NUM_LINES-1:0]   line_valid;
    logic                   rd_valid_q;
    logic                   rsp_valid_q;

    logic                   clr_en, set_en;
    logic [IDX_W-1:0]       clr_idx, set_idx;
    logic                   data_we, tag_we;
    logic [IDX_W+OFF_W-1:0] data_waddr;
    logic [WORD_W:0]        data_wdata, data_rdata;
    logic [IDX_W-1:0]       tag_waddr;
    logic [TAG_W:0]         tag_wdata, tag_rdata;

    logic                   unused_addr_bits;

    assign req_idx  = req_vaddr[IDX_LO +: IDX_W];
    assign req_off  = req_vaddr[BYTE_W +: OFF_W];
    assign inv_idx  = inval_vaddr[IDX_LO +: IDX_W];
    assign fill_idx = refill_vaddr[IDX_LO +: IDX_W];
    assign xlat_tag = xlat_paddr[PAGE_BITS +: TAG_W];
    assign fill_tag = refill_paddr[PAGE_BITS +: TAG_W];

    assign unused_addr_bits = ^{req_vaddr[BYTE_W-1:0], req_vaddr[VADDR_W-1:IDX_HI],
                                inval_vaddr[IDX_LO-1:0], inval_vaddr[VADDR_W-1:IDX_HI],
                                refill_vaddr[IDX_LO-1:0], refill_vaddr[VADDR_W-1:IDX_HI],
                                xlat_paddr[PAGE_BITS-1:0], refill_paddr[PAGE_BITS-1:0]};

    icache_refill_ctrl #(
        .IDX_W      (IDX_W),
        .TAG_W      (TAG_W),
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_fill (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (refill_start),
        .start_idx    (fill_idx),
        .start_tag    (fill_tag),
        .start_inject (refill_perr_inject),
        .wvalid       (refill_wvalid),
        .word         (refill_word),
        .busy         (refill_busy),
        .clr_en       (clr_en),
        .clr_idx      (clr_idx),
        .set_en       (set_en),
        .set_idx      (set_idx),
        .data_we      (data_we),
        .data_waddr   (data_waddr),
        .data_wdata   (data_wdata),
        .tag_we       (tag_we),
        .tag_waddr    (tag_waddr),
        .tag_wdata    (tag_wdata)
    );

    icache_sram #(
        .DEPTH (NUM_LINES),
        .WIDTH (TAG_W + 1)
    ) u_tag_ram (
        .clk   (clk),
        .we    (tag_we),
        .waddr (tag_waddr),
        .wdata (tag_wdata),
        .re    (req_valid),
        .raddr (req_idx),
        .rdata (tag_rdata)
    );

    icache_sram #(
        .DEPTH (DATA_DEPTH),
        .WIDTH (WORD_W + 1)
    ) u_data_ram (
        .clk   (clk),
        .we    (data_we),
        .waddr (data_waddr),
        .wdata (data_wdata),
        .re    (req_valid),
        .raddr ({req_idx, req_off}),
        .rdata (data_rdata)
    );

    // valid bits live in flops so reset clears every line at once;
    // an invalidate wins over a commit to the same index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_valid <= '0;
        end else begin
            if (clr_en)      line_valid[clr_idx] <= 1'b0;
            if (set_en)      line_valid[set_idx] <= 1'b1;
            if (inval_valid) line_valid[inv_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rd_valid_q  <= 1'b0;
        end else begin
            rsp_valid_q <= req_valid;
            if (req_valid) begin
                rd_valid_q <= line_valid[req_idx];
            end
        end
    end

    icache_hit_check #(
        .TAG_W  (TAG_W),
        .WORD_W (WORD_W)
    ) u_hit (
        .active      (rsp_valid_q),
        .line_valid  (rd_valid_q),
        .stored_tag  (tag_rdata[TAG_W-1:0]),
        .stored_tpar (tag_rdata[TAG_W]),
        .stored_word (data_rdata[WORD_W-1:0]),
        .stored_wpar (data_rdata[WORD_W]),
        .xlat_tag    (xlat_tag),
        .hit         (rsp_hit),
        .tag_perr    (rsp_tag_perr),
        .data_perr   (rsp_data_perr)
    );

    assign rsp_valid = rsp_valid_q;
    assign rsp_instr = data_rdata[WORD_W-1:0];

endmodule

// File: rtl/icache_vipt_chk.sv
module icache_vipt_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_tag_perr,
    input logic rsp_data_perr,
    input logic refill_start,
    input logic refill_wvalid,
    input logic refill_busy
);

    assert_resp_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_stray_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_hit_is_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (!rsp_tag_perr && !rsp_data_perr));

    assert_one_error_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_tag_perr && rsp_data_perr));

    assert_quiet_without_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_tag_perr && !rsp_data_perr));

    assert_start_enters_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_start && !refill_busy) |=> refill_busy);

    assert_idle_stays_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!refill_busy && !refill_start) |=> !refill_busy);

    assert_fill_waits_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_busy && !refill_wvalid && $past(refill_busy) && $past(!refill_wvalid)
         && $past(refill_busy, 2)) |=> refill_busy);

endmodule

bind icache_vipt icache_vipt_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_tag_perr  (rsp_tag_perr),
    .rsp_data_perr (rsp_data_perr),
    .refill_start  (refill_start),
    .refill_wvalid (refill_wvalid),
    .refill_busy   (refill_busy)
);

// File: tb/sim_icache_vipt.sv
`timescale 1ns/1ps
module sim_icache_vipt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] xlat_paddr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [31:0] rsp_instr;
    logic        rsp_tag_perr;
    logic        rsp_data_perr;
    logic        inval_valid = 1'b0;
    logic [31:0] inval_vaddr = '0;
    logic        refill_start = 1'b0;
    logic [31:0] refill_vaddr = '0;
    logic [31:0] refill_paddr = '0;
    logic        refill_wvalid = 1'b0;
    logic [31:0] refill_word = '0;
    logic [4:0]  refill_perr_inject = '0;
    logic        refill_busy;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    icache_vipt u0 (
        .clk                (clk),
        .rst_n              (rst_n),
        .req_valid          (req_valid),
        .req_vaddr          (req_vaddr),
        .xlat_paddr         (xlat_paddr),
        .rsp_valid          (rsp_valid),
        .rsp_hit            (rsp_hit),
        .rsp_instr          (rsp_instr),
        .rsp_tag_perr       (rsp_tag_perr),
        .rsp_data_perr      (rsp_data_perr),
        .inval_valid        (inval_valid),
        .inval_vaddr        (inval_vaddr),
        .refill_start       (refill_start),
        .refill_vaddr       (refill_vaddr),
        .refill_paddr       (refill_paddr),
        .refill_wvalid      (refill_wvalid),
        .refill_word        (refill_word),
        .refill_perr_inject (refill_perr_inject),
        .refill_busy        (refill_busy)
    );

    function automatic logic [31:0] pat(input logic [31:0] va, input int k);
        return 32'hC0DE_0000 ^ (va << 4) ^ 32'(k * 32'h0101);
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // request at one edge, physical address and checks in the next cycle
    task automatic fetch(input string rq, input logic [31:0] va, input logic [31:0] pa,
                         input logic exp_hit, input logic [31:0] exp_word,
                         input logic exp_tp, input logic exp_dp);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid  = 1'b0;
        xlat_paddr = pa;
        #1;
        chk(rq, "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(rq, "rsp_hit", 32'(rsp_hit), 32'(exp_hit));
        chk(rq, "rsp_tag_perr", 32'(rsp_tag_perr), 32'(exp_tp));
        chk(rq, "rsp_data_perr", 32'(rsp_data_perr), 32'(exp_dp));
        if (exp_hit) chk(rq, "rsp_instr", rsp_instr, exp_word);
    endtask

    task automatic refill(input logic [31:0] va, input logic [31:0] pa, input logic [4:0] inj);
        @(negedge clk);
        refill_start       = 1'b1;
        refill_vaddr       = va;
        refill_paddr       = pa;
        refill_perr_inject = inj;
        @(negedge clk);
        refill_start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            refill_wvalid = 1'b1;
            refill_word   = pat(va, k);
            @(negedge clk);
        end
        refill_wvalid = 1'b0;
    endtask

    task automatic invalidate(input logic [31:0] va);
        @(negedge clk);
        inval_valid = 1'b1;
        inval_vaddr = va;
        @(negedge clk);
        inval_valid = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        chk("R1", "refill_busy after reset", 32'(refill_busy), 32'd0);
        chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        fetch("R1", 32'h0000_0100, 32'h0000_0100, 1'b0, '0, 1'b0, 1'b0);
        fetch("R1", 32'h0000_0FF0, 32'hFFFF_FFF0, 1'b0, '0, 1'b0, 1'b0);
        @(negedge clk);
        #1;
        chk("R12", "rsp_valid idle", 32'(rsp_valid), 32'd0);
        chk("R12", "rsp_hit idle", 32'(rsp_hit), 32'd0);
    endtask

    task automatic t_basic;
        refill(32'h0000_0230, 32'h1234_5400, 5'b0);
        for (int k = 0; k < 4; k++) begin
            // R2, R11: each offset selects its own word, no parity flags
            fetch("R2", 32'h0000_0230 | 32'(k << 2), 32'h1234_5400, 1'b1,
                  pat(32'h0000_0230, k), 1'b0, 1'b0);
        end
        fetch("R11", 32'h0000_0238, 32'h1234_5400, 1'b1, pat(32'h0000_0230, 2), 1'b0, 1'b0);
        @(negedge clk);
        #1;
        chk("R12", "rsp_hit after response", 32'(rsp_hit), 32'd0);
    endtask

    task automatic t_tag;
        fetch("R3", 32'h0000_0230, 32'h9234_5400, 1'b0, '0, 1'b0, 1'b0);
        fetch("R3", 32'h0000_0230, 32'h1234_5C00, 1'b0, '0, 1'b0, 1'b0);
        fetch("R3", 32'h0000_0234, 32'h1234_57FF, 1'b1, pat(32'h0000_0230, 1), 1'b0, 1'b0);
    endtask

    task automatic t_index;
        fetch("R4", 32'hFFFF_F23C, 32'h1234_5400, 1'b1, pat(32'h0000_0230, 3), 1'b0, 1'b0);
        fetch("R4", 32'h0000_0240, 32'h1234_5400, 1'b0, '0, 1'b0, 1'b0);
    endtask

    // refill the same index with a new tag, probing mid-fill
    task automatic t_visibility;
        @(negedge clk);
        refill_start = 1'b1;
        refill_vaddr = 32'h0000_0230;
        refill_paddr = 32'h5678_9C00;
        refill_perr_inject = 5'b0;
        @(negedge clk);
        refill_start  = 1'b0;
        refill_wvalid = 1'b1;
        refill_word   = pat(32'h0000_1230, 0);
        req_valid     = 1'b1;
        req_vaddr     = 32'h0000_0230;
        @(negedge clk);
        req_valid   = 1'b0;
        xlat_paddr  = 32'h1234_5400;
        refill_word = pat(32'h0000_1230, 1);
        #1;
        chk("R5", "old line during fill hit", 32'(rsp_hit), 32'd0);
        chk("R5", "refill_busy during fill", 32'(refill_busy), 32'd1);
        @(negedge clk);
        refill_word = pat(32'h0000_1230, 2);
        @(negedge clk);
        refill_word = pat(32'h0000_1230, 3);
        @(negedge clk);
        refill_wvalid = 1'b0;
        #1;
        chk("R5", "refill_busy in commit", 32'(refill_busy), 32'd1);
        fetch("R5", 32'h0000_0234, 32'h5678_9C00, 1'b1, pat(32'h0000_1230, 1), 1'b0, 1'b0);
        fetch("R7", 32'h0000_0234, 32'h1234_5400, 1'b0, '0, 1'b0, 1'b0);
        chk("R5", "refill_busy after commit", 32'(refill_busy), 32'd0);
    endtask

    task automatic t_inval;
        refill(32'h0000_0400, 32'h0AAA_A000, 5'b0);
        refill(32'h0000_0410, 32'h0BBB_B000, 5'b0);
        invalidate(32'h7000_0404);
        fetch("R6", 32'h0000_0400, 32'h0AAA_A000, 1'b0, '0, 1'b0, 1'b0);
        fetch("R6", 32'h0000_0410, 32'h0BBB_B000, 1'b1, pat(32'h0000_0410, 0), 1'b0, 1'b0);
    endtask

    task automatic t_tag_par;
        refill(32'h0000_0500, 32'h0CCC_C400, 5'b10000);
        fetch("R8", 32'h0000_0504, 32'h0CCC_C400, 1'b0, '0, 1'b1, 1'b0);
    endtask

    task automatic t_data_par;
        refill(32'h0000_0600, 32'h0DDD_D800, 5'b00100);
        fetch("R9", 32'h0000_0608, 32'h0DDD_D800, 1'b0, '0, 1'b0, 1'b1);
        fetch("R9", 32'h0000_0604, 32'h0DDD_D800, 1'b1, pat(32'h0000_0600, 1), 1'b0, 1'b0);
        fetch("R9", 32'h0000_0608, 32'h3DDD_D800, 1'b0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_busy;
        refill(32'h0000_0710, 32'h0EEE_E000, 5'b0);
        @(negedge clk);
        refill_start = 1'b1;
        refill_vaddr = 32'h0000_0700;
        refill_paddr = 32'h0FFF_F000;
        refill_perr_inject = 5'b0;
        @(negedge clk);
        refill_wvalid = 1'b1;
        refill_word   = pat(32'h0000_0700, 0);
        refill_vaddr  = 32'h0000_0710;
        refill_paddr  = 32'h0111_1000;
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            refill_start = 1'b0;
            refill_word  = pat(32'h0000_0700, k);
        end
        @(negedge clk);
        refill_wvalid = 1'b0;
        fetch("R10", 32'h0000_070C, 32'h0FFF_F000, 1'b1, pat(32'h0000_0700, 3), 1'b0, 1'b0);
        fetch("R10", 32'h0000_0714, 32'h0EEE_E000, 1'b1, pat(32'h0000_0710, 1), 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_tag();
        t_index();
        t_visibility();
        t_inval();
        t_tag_par();
        t_data_par();
        t_busy();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule